// File: doc/BRIEF.md
# Receive Ring Retirement Walker

This block retires finished frames from a sixteen-slot receive descriptor ring. When the receive threshold interrupt fires, the block takes the hardware read position from the interrupt status word. If the underflow flag is also set, it steps that position back by one. It then walks its own slot index forward, one slot at a time, until the index reaches that position.

For each slot the block:
- reads the 64-bit status word;
- decides whether the frame is good, has an illegal length, was dropped for lack of a spare buffer, or carries errors;
- reports the frame length with the four CRC bytes removed;
- updates saturating statistics counters;
- writes the slot status back to zero.

The receive interrupt enable is masked while a walk runs. At the end of the walk the block pulses a threshold acknowledge and re-arms both the receive interrupt enable and the receive enable.

Status words come from the ring memory through a one-cycle read port, and the clearing goes back through a write strobe. A surrounding buffer manager tells the block through `spare_ok` whether a fresh buffer exists for a good frame.

Top module: `rxring_retire`

## Requirements
- R1: A walk starts only when `irq_valid` is high, bit 0 (threshold) of `int_status` is set and the block is idle. Any other `irq_valid` pulse is ignored. The hardware ring position is `int_status[11:8]`.
- R2: When bit 6 (underflow) of `int_status` is set at the start, the walk target is (position − 1) mod 16 and `rx_en` drops to 0 for the walk.
- R3: Slots are retired from the local index up to, but not including, the target, wrapping from 15 to 0. The index is kept between walks and is 0 after reset. A walk whose target equals the index retires nothing but still completes.
- R4: Each slot is fetched by a one-cycle `rd_en` with `rd_idx`. `rd_data` is expected in the next cycle, and the verdict (`vd_valid`, `vd_idx`) appears in that same cycle.
- R5: Status layout is: length in bits [15:0], six error flags in bits [21:16], valid flag in bit 31. Verdict codes on `vd_kind` are 0 good, 1 bad length, 2 dropped, 3 errored.
- R6: `vd_len` is status[15:0] − 4. For a valid, error-free frame, a length below 60 or above 1518 gives code 1 and increments both `err_cnt` and `lenerr_cnt`.
- R7: A frame with the valid flag clear or any error flag set gives code 3 and increments `err_cnt` only.
- R8: A frame that is valid, error-free and within the length window gives code 2 and increments `drop_cnt` when `spare_ok` is low.
- R9: A good frame (code 0) increments `pkt_cnt` by one and adds its length to `byte_cnt`.
- R10: In every verdict cycle `clr_en` is high with `clr_idx` equal to `vd_idx`, so the slot status becomes zero.
- R11: `rx_int_en` is low from the cycle after a walk starts until the walk ends. The end is one `thr_ack` pulse, after which `rx_int_en` and `rx_en` are both 1.
- R12: Every counter saturates at its all-ones value instead of wrapping.
- R13: After reset all counters are 0, `rx_int_en` and `rx_en` are 1, and `rd_en`, `vd_valid`, `clr_en` and `thr_ack` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_valid | input | 1 | Interrupt status word presented |
| int_status | input | 32 | Interrupt status word |
| spare_ok | input | 1 | A replacement buffer is available |
| rd_en | output | 1 | Ring status read request |
| rd_idx | output | 4 | Slot to read |
| rd_data | input | 64 | Slot status, one cycle after the request |
| clr_en | output | 1 | Clear slot status |
| clr_idx | output | 4 | Slot to clear |
| vd_valid | output | 1 | Verdict present |
| vd_idx | output | 4 | Slot of the verdict |
| vd_kind | output | 2 | Verdict code |
| vd_len | output | 16 | Frame length without CRC |
| pkt_cnt | output | CNT_W | Good frames |
| byte_cnt | output | CNT_W | Bytes in good frames |
| err_cnt | output | CNT_W | Errored and bad-length frames |
| lenerr_cnt | output | CNT_W | Bad-length frames |
| drop_cnt | output | CNT_W | Frames dropped for lack of a buffer |
| thr_ack | output | 1 | Threshold acknowledge pulse |
| rx_int_en | output | 1 | Receive interrupt enable |
| rx_en | output | 1 | Receive enable |

## Verification
A corrupted slot index shows at once on the first `rd_idx` and `vd_idx` of the next walk. It also shows as a wrong number of verdicts before `thr_ack`, because the walk stops at the first slot equal to the target.

A wrong classification shows in the verdict cycle itself. It also appears one cycle later as the wrong counter moving. That counter error persists, because saturating counters never return to the right value.

A stuck enable state shows in the cycle after `thr_ack`, or as later walks being refused.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    localparam int IDX_W     = 4;
    localparam int STAT_W    = 64;
    localparam int IRQ_W     = 32;
    localparam int LEN_W     = 16;
    localparam int PTR_LSB   = 8;
    localparam int THR_BIT   = 0;
    localparam int UFLOW_BIT = 6;
    localparam int ERR_LSB   = 16;
    localparam int ERR_N     = 6;
    localparam int VALID_BIT = 31;
    localparam int CRC_BYTES = 4;
    localparam int MIN_LEN   = 60;
    localparam int MAX_LEN   = 1518;
    localparam int N_CNT     = 5;

    typedef enum logic [1:0] {
        VD_GOOD   = 2'd0,
        VD_BADLEN = 2'd1,
        VD_DROP   = 2'd2,
        VD_ERR    = 2'd3
    } verdict_e;

    typedef enum logic [1:0] {
        W_IDLE,
        W_FETCH,
        W_CHECK,
        W_DONE
    } wstate_e;

    typedef struct packed {
        verdict_e          kind;
        logic [LEN_W-1:0]  len;
    } verdict_t;

    // Order of the counter slots inside the counter bank
    localparam int C_PKT  = 0;
    localparam int C_BYTE = 1;
    localparam int C_ERR  = 2;
    localparam int C_LEN  = 3;
    localparam int C_DROP = 4;

    function automatic verdict_t classify(input logic [STAT_W-1:0] st,
                                          input logic spare);
        verdict_t v;
        v.len = st[LEN_W-1:0] - LEN_W'(CRC_BYTES);
        if (!st[VALID_BIT] || (|st[ERR_LSB +: ERR_N]))
            v.kind = VD_ERR;
        else if (v.len < LEN_W'(MIN_LEN) || v.len > LEN_W'(MAX_LEN))
            v.kind = VD_BADLEN;
        else if (!spare)
            v.kind = VD_DROP;
        else
            v.kind = VD_GOOD;
        return v;
    endfunction

endpackage

// File: rtl/rxr_sat_cnt.sv
module rxr_sat_cnt #(
    parameter int W  = 32,
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  q
);
    localparam int SW = ((W > AW) ? W : AW) + 1;
    localparam logic [SW-1:0] TOP = SW'({W{1'b1}});

    logic [SW-1:0] sum;

    always_comb sum = SW'(q) + SW'(amt);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (en)
            q <= (sum > TOP) ? {W{1'b1}} : sum[W-1:0];
    end

    // R12: the count never moves backwards
    a_r12_no_wrap: assert property (@(posedge clk) disable iff (rst)
        q >= $past(q));
endmodule

// File: rtl/rxr_walker.sv
module rxr_walker
    import rxr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             irq_valid,
    input  logic [IRQ_W-1:0] int_status,
    output logic             fetch,
    output logic             check,
    output logic [IDX_W-1:0] idx,
    output logic             ack,
    output logic             int_en,
    output logic             rcv_en
);
    wstate_e          st;
    logic [IDX_W-1:0] tgt;
    logic [IDX_W-1:0] hw_ptr;
    logic [IDX_W-1:0] eff_ptr;
    logic             start;
    logic [IDX_W-1:0] idx_nx;

    always_comb begin
        hw_ptr  = int_status[PTR_LSB +: IDX_W];
        eff_ptr = int_status[UFLOW_BIT] ? hw_ptr - 1'b1 : hw_ptr;
        start   = (st == W_IDLE) && irq_valid && int_status[THR_BIT];
        idx_nx  = idx + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= W_IDLE;
            idx    <= '0;
            tgt    <= '0;
            int_en <= 1'b1;
            rcv_en <= 1'b1;
        end else begin
            case (st)
                W_IDLE: if (start) begin
                    int_en <= 1'b0;
                    tgt    <= eff_ptr;
                    if (int_status[UFLOW_BIT]) rcv_en <= 1'b0;
                    st     <= (idx == eff_ptr) ? W_DONE : W_FETCH;
                end
                W_FETCH: st <= W_CHECK;
                W_CHECK: begin
                    idx <= idx_nx;
                    st  <= (idx_nx == tgt) ? W_DONE : W_FETCH;
                end
                default: begin
                    int_en <= 1'b1;
                    rcv_en <= 1'b1;
                    st     <= W_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        fetch = (st == W_FETCH);
        check = (st == W_CHECK);
        ack   = (st == W_DONE);
    end

    // R11: interrupt enable stays masked while slots are being fetched
    a_r11_masked_in_walk: assert property (@(posedge clk) disable iff (rst)
        fetch |-> !int_en);
    // R11: the acknowledge re-arms both enables
    a_r11_ack_rearms: assert property (@(posedge clk) disable iff (rst)
        ack |=> (int_en && rcv_en));
    // R3: consecutive checks step the index by one
    a_r3_step_one: assert property (@(posedge clk) disable iff (rst)
        (check && !ack) |=> (idx == $past(idx) + 1'b1));
endmodule

// File: rtl/rxring_retire.sv
module rxring_retire
    import rxr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                irq_valid,
    input  logic [IRQ_W-1:0]    int_status,
    input  logic                spare_ok,
    output logic                rd_en,
    output logic [IDX_W-1:0]    rd_idx,
    input  logic [STAT_W-1:0]   rd_data,
    output logic                clr_en,
    output logic [IDX_W-1:0]    clr_idx,
    output logic                vd_valid,
    output logic [IDX_W-1:0]    vd_idx,
    output logic [1:0]          vd_kind,
    output logic [LEN_W-1:0]    vd_len,
    output logic [CNT_W-1:0]    pkt_cnt,
    output logic [CNT_W-1:0]    byte_cnt,
    output logic [CNT_W-1:0]    err_cnt,
    output logic [CNT_W-1:0]    lenerr_cnt,
    output logic [CNT_W-1:0]    drop_cnt,
    output logic                thr_ack,
    output logic                rx_int_en,
    output logic                rx_en
);
    logic             fetch, check;
    logic [IDX_W-1:0] idx;
    verdict_t         vd;

    logic [N_CNT-1:0] cnt_en;
    logic [LEN_W-1:0] cnt_amt [N_CNT];
    logic [CNT_W-1:0] cnt_q   [N_CNT];

    rxr_walker walker_i (
        .clk       (clk),
        .rst       (rst),
        .irq_valid (irq_valid),
        .int_status(int_status),
        .fetch     (fetch),
        .check     (check),
        .idx       (idx),
        .ack       (thr_ack),
        .int_en    (rx_int_en),
        .rcv_en    (rx_en)
    );

    always_comb begin
        vd       = classify(rd_data, spare_ok);
        rd_en    = fetch;
        rd_idx   = idx;
        vd_valid = check;
        vd_idx   = idx;
        vd_kind  = vd.kind;
        vd_len   = vd.len;
        clr_en   = check;
        clr_idx  = idx;

        cnt_en[C_PKT]   = check && (vd.kind == VD_GOOD);
        cnt_en[C_BYTE]  = check && (vd.kind == VD_GOOD);
        cnt_en[C_ERR]   = check && ((vd.kind == VD_ERR) || (vd.kind == VD_BADLEN));
        cnt_en[C_LEN]   = check && (vd.kind == VD_BADLEN);
        cnt_en[C_DROP]  = check && (vd.kind == VD_DROP);
        cnt_amt[C_PKT]  = LEN_W'(1);
        cnt_amt[C_BYTE] = vd.len;
        cnt_amt[C_ERR]  = LEN_W'(1);
        cnt_amt[C_LEN]  = LEN_W'(1);
        cnt_amt[C_DROP] = LEN_W'(1);
    end

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        rxr_sat_cnt #(.W(CNT_W), .AW(LEN_W)) cnt_i (
            .clk(clk),
            .rst(rst),
            .en (cnt_en[g]),
            .amt(cnt_amt[g]),
            .q  (cnt_q[g])
        );
    end

    always_comb begin
        pkt_cnt    = cnt_q[C_PKT];
        byte_cnt   = cnt_q[C_BYTE];
        err_cnt    = cnt_q[C_ERR];
        lenerr_cnt = cnt_q[C_LEN];
        drop_cnt   = cnt_q[C_DROP];
    end

    // R4: a read request is answered by a verdict for the same slot next cycle
    a_r4_fetch_verdict: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> (vd_valid && vd_idx == $past(rd_idx)));
    // R6: a good verdict always carries a length inside the window
    a_r6_good_window: assert property (@(posedge clk) disable iff (rst)
        (vd_valid && vd_kind == VD_GOOD) |->
            (vd_len >= LEN_W'(MIN_LEN) && vd_len <= LEN_W'(MAX_LEN)));
    // R9: bytes only accumulate together with a good packet
    a_r9_bytes_with_pkt: assert property (@(posedge clk) disable iff (rst)
        (byte_cnt != $past(byte_cnt)) |-> (pkt_cnt != $past(pkt_cnt)));
    // R6: a length error is always also counted as an error
    a_r6_lenerr_with_err: assert property (@(posedge clk) disable iff (rst)
        (lenerr_cnt != $past(lenerr_cnt)) |->
            (err_cnt != $past(err_cnt) || err_cnt == {CNT_W{1'b1}}));
endmodule

// File: tb/rxring_retire_tb_top.sv
module rxring_retire_tb_top;
    localparam int CW = 12;
    localparam longint CMAX = (64'd1 << CW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          irq_valid = 1'b0;
    logic [31:0]   int_status = '0;
    logic          spare_ok = 1'b1;
    logic          rd_en, clr_en, vd_valid, thr_ack, rx_int_en, rx_en;
    logic [3:0]    rd_idx, clr_idx, vd_idx;
    logic [63:0]   rd_data = '0;
    logic [1:0]    vd_kind;
    logic [15:0]   vd_len;
    logic [CW-1:0] pkt_cnt, byte_cnt, err_cnt, lenerr_cnt, drop_cnt;

    logic [63:0] ring [16];

    rxring_retire #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .irq_valid(irq_valid), .int_status(int_status),
        .spare_ok(spare_ok), .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
        .clr_en(clr_en), .clr_idx(clr_idx), .vd_valid(vd_valid), .vd_idx(vd_idx),
        .vd_kind(vd_kind), .vd_len(vd_len), .pkt_cnt(pkt_cnt), .byte_cnt(byte_cnt),
        .err_cnt(err_cnt), .lenerr_cnt(lenerr_cnt), .drop_cnt(drop_cnt),
        .thr_ack(thr_ack), .rx_int_en(rx_int_en), .rx_en(rx_en)
    );

    // Ring memory model: registered read, clear on strobe
    always @(posedge clk) begin
        if (rd_en) rd_data <= ring[rd_idx];
        if (clr_en) ring[clr_idx] <= 64'd0;
    end

    int n_chk = 0;
    int n_bad = 0;
    logic [3:0] e_idx = 4'd0;
    longint e_pkt = 0, e_byte = 0, e_err = 0, e_len = 0, e_drop = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint sat(input longint c, input longint a);
        return (c + a > CMAX) ? CMAX : c + a;
    endfunction

    function automatic logic [63:0] mk(input bit valid, input logic [5:0] err,
                                       input logic [15:0] raw);
        return {32'd0, valid, 9'd0, err, raw};
    endfunction

    function automatic logic [63:0] rnd_status();
        int r = $urandom;
        bit v = (r % 8) != 0;
        logic [5:0] e = ((r / 8) % 10 == 0) ? 6'(1 << ((r / 80) % 6)) : 6'd0;
        logic [15:0] raw = 16'($urandom_range(1540, 50));
        return mk(v, e, raw);
    endfunction

    // Expected verdict code: 0 good, 1 bad length, 2 drop, 3 error
    function automatic int exp_kind(input logic [63:0] s, input bit spare);
        logic [15:0] l = s[15:0] - 16'd4;
        if (!s[31] || |s[21:16]) return 3;
        if (l < 16'd60 || l > 16'd1518) return 1;
        if (!spare) return 2;
        return 0;
    endfunction

    task automatic check_counters(input string tag);
        chk(pkt_cnt == CW'(e_pkt), "R9", {tag, " pkt_cnt"}, pkt_cnt, e_pkt);
        chk(byte_cnt == CW'(e_byte), "R9", {tag, " byte_cnt"}, byte_cnt, e_byte);
        chk(err_cnt == CW'(e_err), "R7", {tag, " err_cnt"}, err_cnt, e_err);
        chk(lenerr_cnt == CW'(e_len), "R6", {tag, " lenerr_cnt"}, lenerr_cnt, e_len);
        chk(drop_cnt == CW'(e_drop), "R8", {tag, " drop_cnt"}, drop_cnt, e_drop);
    endtask

    task automatic walk(input logic [31:0] stat, input bit spare);
        logic [3:0] tgt = stat[6] ? stat[11:8] - 4'd1 : stat[11:8];
        int want = int'(4'(tgt - e_idx));
        int seen = 0;
        int guard = 0;
        logic [15:0] cleared = '0;
        @(negedge clk);
        irq_valid = 1'b1; int_status = stat; spare_ok = spare;
        @(negedge clk);
        irq_valid = 1'b0;
        chk(rx_int_en == 1'b0, "R11", "int enable masked at start", rx_int_en, 0);
        if (stat[6]) chk(rx_en == 1'b0, "R2", "rx_en dropped on underflow", rx_en, 0);
        while (!thr_ack && guard < 200) begin
            if (vd_valid) begin
                int k = exp_kind(ring[e_idx], spare);
                logic [15:0] l = ring[e_idx][15:0] - 16'd4;
                chk(vd_idx == e_idx, "R3", "verdict slot", vd_idx, e_idx);
                chk(int'(vd_kind) == k, "R5", "verdict code", vd_kind, k);
                chk(vd_len == l, "R6", "length minus CRC", vd_len, l);
                chk(clr_en && clr_idx == e_idx, "R10", "clear strobe slot", clr_idx, e_idx);
                case (k)
                    0: begin e_pkt = sat(e_pkt, 1); e_byte = sat(e_byte, l); end
                    1: begin e_err = sat(e_err, 1); e_len = sat(e_len, 1); end
                    2: e_drop = sat(e_drop, 1);
                    default: e_err = sat(e_err, 1);
                endcase
                cleared[e_idx] = 1'b1;
                e_idx = e_idx + 4'd1;
                seen++;
            end
            @(negedge clk);
            guard++;
        end
        chk(guard < 200, "R11", "walk ended with ack", guard, 0);
        chk(seen == want, "R3", "slots retired", seen, want);
        @(negedge clk);
        chk(thr_ack == 1'b0, "R11", "ack is a single pulse", thr_ack, 0);
        chk(rx_int_en && rx_en, "R11", "enables rearmed", {rx_int_en, rx_en}, 3);
        for (int i = 0; i < 16; i++)
            if (cleared[i]) chk(ring[i] == 64'd0, "R10", "slot status zeroed", ring[i][31:0], 0);
        check_counters("after walk");
    endtask

    initial begin
        int wd = 0;
        while (wd < 150000) begin @(posedge clk); wd++; end
        chk(1'b0, "R3", "watchdog expired", wd, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < 16; i++) ring[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        chk(!rd_en && !vd_valid && !clr_en && !thr_ack, "R13", "strobes idle", rd_en, 0);
        chk(rx_int_en && rx_en, "R13", "enables set", {rx_int_en, rx_en}, 3);
        check_counters("reset R13");

        // R1: pulse without threshold bit is ignored
        irq_valid = 1'b1; int_status = 32'h0000_0500;
        @(negedge clk); irq_valid = 1'b0;
        repeat (4) begin
            chk(!rd_en && !thr_ack && rx_int_en, "R1", "no walk without threshold", rd_en, 0);
            @(negedge clk);
        end

        // R3: target equals index, empty walk that still acknowledges
        walk(32'h0000_0001, 1'b1);

        // R6 window edges: raw 64 (60), 63 (59), 1522 (1518), 1523 (1519)
        ring[0] = mk(1, 0, 16'd64);
        ring[1] = mk(1, 0, 16'd63);
        ring[2] = mk(1, 0, 16'd1522);
        ring[3] = mk(1, 0, 16'd1523);
        ring[4] = mk(0, 0, 16'd100);           // R7 not valid
        ring[5] = mk(1, 6'b100000, 16'd100);   // R7 error flag
        walk(32'h0000_0601, 1'b1);

        // R8: no spare buffer
        ring[6] = mk(1, 0, 16'd200);
        ring[7] = mk(1, 6'b000001, 16'd200);
        walk(32'h0000_0801, 1'b0);

        // R2: underflow steps the pointer back: position 11 -> target 10
        for (int i = 8; i < 11; i++) ring[i] = mk(1, 0, 16'd300);
        walk(32'h0000_0B41, 1'b1);

        // R3: wrap from 15 to 0
        for (int i = 10; i < 16; i++) ring[i] = rnd_status();
        for (int i = 0; i < 3; i++) ring[i] = rnd_status();
        walk(32'h0000_0301, 1'b1);

        // Random walks
        for (int w = 0; w < 30; w++) begin
            logic [31:0] s = 32'h1 | ({28'd0, 4'($urandom)} << 8)
                           | (($urandom % 5 == 0) ? 32'h40 : 32'h0);
            logic [3:0] t = s[6] ? s[11:8] - 4'd1 : s[11:8];
            for (int i = 0; i < 16; i++)
                if (4'(4'(i) - e_idx) < 4'(t - e_idx)) ring[i] = rnd_status();
            walk(s, ($urandom % 6) != 0);
        end

        // R12: drive the byte counter to its ceiling
        for (int i = 0; i < 16; i++) ring[i] = mk(1, 0, 16'd1504);
        walk({20'd0, 4'(e_idx + 4'd15), 8'h01}, 1'b1);
        chk(byte_cnt == CW'(CMAX), "R12", "byte counter saturated", byte_cnt, CMAX);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule